// File: doc/BRIEF.md
# Deferred Serial Line Configuration Commit

This block sits between a host register interface and a serial transmitter. It keeps a shadow copy of each line setting (handshake/mode byte, port output byte, character format byte and a 10-bit baud divider). A host write only changes the shadow copy and raises a pending flag. The live registers seen by the serializer change only at a clock edge where the transmitter reports idle. At that edge all settings move across together, so a character on the line never sees a half-applied change of speed, framing or break state.

The divider does not map to one live register. Its low byte drives a dedicated output. Its two top bits land in the two top bits of an auxiliary live register. The host writes the six low bits of that register directly, and those writes are not deferred. The break-transmit request is a single bit of the format byte, so a break is started or ended only at an idle point, the same as any other format change.

Top module: `uart_cfg_defer`

## Requirements
- R1: After reset, mode_o, port_o, fmt_o and div_lo_o hold their parameter defaults. aux_o holds the top two divider default bits above the auxiliary default low bits. pending_o is 0.
- R2: Any of mode_we_i, port_we_i, fmt_we_i, brk_we_i or div_we_i high at a clock edge sets pending_o after that edge. While tx_idle_i is low, no live output except aux_o[5:0] changes.
- R3: At an edge where pending_o and tx_idle_i are both high, mode_o, port_o, fmt_o, div_lo_o and aux_o[7:6] all take their shadow values at that same edge, and pending_o clears unless a write strobe is also active.
- R4: A write made while tx_idle_i is already high reaches the live outputs at the next edge after the write edge.
- R5: On commit, div_lo_o takes divider bits 7:0 and aux_o[7:6] takes divider bits 9:8. aux_o[5:0] is not changed by a commit.
- R6: aux_we_i writes aux_wdata_i[5:0] into aux_o[5:0] at the next edge, whatever the state of pending_o or tx_idle_i. It does not set pending_o.
- R7: brk_we_i copies brk_val_i into bit 6 of the format shadow and leaves its other bits alone. If fmt_we_i is high in the same cycle, bit 6 comes from brk_val_i and the rest comes from fmt_wdata_i. The change reaches fmt_o only on commit.
- R8: The format byte is carried bit for bit. Bits 1:0 are the length code (0..3 for 5..8 data bits), bit 2 selects two stop bits, bit 3 enables parity, bit 4 selects odd parity, bit 6 is break, and bits 5 and 7 are stored as written.
- R9: A shadow write in the same cycle as a commit does not reach the live outputs at that edge: the commit moves the older shadow value, pending_o stays 1, and the new value is committed at the next idle edge.
- R10: While tx_idle_i stays low, pending_o stays set and the live outputs hold for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode shadow write strobe |
| mode_wdata_i | input | 8 | Mode shadow write data |
| port_we_i | input | 1 | Port-value shadow write strobe |
| port_wdata_i | input | 8 | Port-value shadow write data |
| fmt_we_i | input | 1 | Format shadow write strobe |
| fmt_wdata_i | input | 8 | Format shadow write data |
| brk_we_i | input | 1 | Break bit shadow write strobe |
| brk_val_i | input | 1 | Break bit value |
| div_we_i | input | 1 | Divider shadow write strobe |
| div_wdata_i | input | 10 | Divider shadow write data |
| aux_we_i | input | 1 | Direct write strobe for aux low bits |
| aux_wdata_i | input | 8 | Aux write data, bits 5:0 used |
| tx_idle_i | input | 1 | Transmitter idle indication |
| mode_o | output | 8 | Live mode register |
| port_o | output | 8 | Live port-value register |
| fmt_o | output | 8 | Live format register |
| div_lo_o | output | 8 | Live divider low byte |
| aux_o | output | 8 | Live aux register: divider bits 9:8 in 7:6, host bits in 5:0 |
| pending_o | output | 1 | Shadow not yet committed |

## Verification
Properties checked on every cycle: live outputs stay frozen when no commit happens, a commit copies every shadow (with the divider split) in one edge, pending is set by a strobe and cleared only by a commit, and the direct aux writes land. The bench has to show the rest. It sweeps all format and divider values, checks the reset defaults, and checks that the break merges with a format write in the same cycle. It also checks the ordering when a write lands on a commit edge, which needs a known history of shadow values.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int REG_W    = 8;
  localparam int BRK_BIT  = 6;
  localparam int LEN_LSB  = 0;
  localparam int STOP_BIT = 2;
  localparam int PAR_EN   = 3;
  localparam int PAR_ODD  = 4;
endpackage

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
  parameter int          DATA_W   = 8,
  parameter int          DIV_W    = 10,
  parameter int          BRK_POS  = 6,
  parameter [DATA_W-1:0] MODE_RST = '0,
  parameter [DATA_W-1:0] PORT_RST = '0,
  parameter [DATA_W-1:0] FMT_RST  = '0,
  parameter [DIV_W-1:0]  DIV_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [DATA_W-1:0] mode_wdata_i,
  input  logic              port_we_i,
  input  logic [DATA_W-1:0] port_wdata_i,
  input  logic              fmt_we_i,
  input  logic [DATA_W-1:0] fmt_wdata_i,
  input  logic              brk_we_i,
  input  logic              brk_val_i,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] sh_mode_o,
  output logic [DATA_W-1:0] sh_port_o,
  output logic [DATA_W-1:0] sh_fmt_o,
  output logic [DIV_W-1:0]  sh_div_o,
  output logic              pending_o
);
  logic [DATA_W-1:0] fmt_d;
  logic              any_we;

  assign any_we = mode_we_i | port_we_i | fmt_we_i | brk_we_i | div_we_i;

  // break bit merges over a full format write
  always_comb begin
    fmt_d = sh_fmt_o;
    if (fmt_we_i) fmt_d = fmt_wdata_i;
    if (brk_we_i) fmt_d[BRK_POS] = brk_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_mode_o <= MODE_RST;
      sh_port_o <= PORT_RST;
      sh_fmt_o  <= FMT_RST;
      sh_div_o  <= DIV_RST;
      pending_o <= 1'b0;
    end else begin
      if (mode_we_i) sh_mode_o <= mode_wdata_i;
      if (port_we_i) sh_port_o <= port_wdata_i;
      if (div_we_i)  sh_div_o  <= div_wdata_i;
      sh_fmt_o <= fmt_d;
      // a write on the commit edge wins: stays pending
      if (any_we)        pending_o <= 1'b1;
      else if (commit_i) pending_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_live.sv
module cfg_live #(
  parameter int          DATA_W   = 8,
  parameter int          DIV_W    = 10,
  parameter [DATA_W-1:0] MODE_RST = '0,
  parameter [DATA_W-1:0] PORT_RST = '0,
  parameter [DATA_W-1:0] FMT_RST  = '0,
  parameter [DIV_W-1:0]  DIV_RST  = '0,
  parameter [DATA_W-1:0] AUX_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] sh_mode_i,
  input  logic [DATA_W-1:0] sh_port_i,
  input  logic [DATA_W-1:0] sh_fmt_i,
  input  logic [DIV_W-1:0]  sh_div_i,
  input  logic              aux_we_i,
  input  logic [DATA_W-1:0] aux_wdata_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] port_o,
  output logic [DATA_W-1:0] fmt_o,
  output logic [DATA_W-1:0] div_lo_o,
  output logic [DATA_W-1:0] aux_o
);
  localparam int HI_W = DIV_W - DATA_W;
  localparam int LO_W = DATA_W - HI_W;

  logic [HI_W-1:0] aux_hi;
  logic [LO_W-1:0] aux_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_RST;
      port_o   <= PORT_RST;
      fmt_o    <= FMT_RST;
      div_lo_o <= DIV_RST[DATA_W-1:0];
      aux_hi   <= DIV_RST[DIV_W-1:DATA_W];
    end else if (commit_i) begin
      mode_o   <= sh_mode_i;
      port_o   <= sh_port_i;
      fmt_o    <= sh_fmt_i;
      div_lo_o <= sh_div_i[DATA_W-1:0];
      aux_hi   <= sh_div_i[DIV_W-1:DATA_W];
    end
  end

  // host-owned low bits of aux are not deferred
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       aux_lo <= AUX_RST[LO_W-1:0];
    else if (aux_we_i) aux_lo <= aux_wdata_i[LO_W-1:0];
  end

  assign aux_o = {aux_hi, aux_lo};
endmodule

// File: rtl/uart_cfg_defer.sv
module uart_cfg_defer
  import uart_cfg_pkg::*;
#(
  parameter int         DIV_W    = 10,
  parameter [REG_W-1:0] MODE_RST = 8'h0C,
  parameter [REG_W-1:0] PORT_RST = 8'hFF,
  parameter [REG_W-1:0] FMT_RST  = 8'h03,
  parameter [DIV_W-1:0] DIV_RST  = 10'h12F,
  parameter [REG_W-1:0] AUX_RST  = 8'h05
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic [REG_W-1:0] mode_wdata_i,
  input  logic             port_we_i,
  input  logic [REG_W-1:0] port_wdata_i,
  input  logic             fmt_we_i,
  input  logic [REG_W-1:0] fmt_wdata_i,
  input  logic             brk_we_i,
  input  logic             brk_val_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             aux_we_i,
  input  logic [REG_W-1:0] aux_wdata_i,
  input  logic             tx_idle_i,
  output logic [REG_W-1:0] mode_o,
  output logic [REG_W-1:0] port_o,
  output logic [REG_W-1:0] fmt_o,
  output logic [REG_W-1:0] div_lo_o,
  output logic [REG_W-1:0] aux_o,
  output logic             pending_o
);
  logic [REG_W-1:0] sh_mode, sh_port, sh_fmt;
  logic [DIV_W-1:0] sh_div;
  logic             commit;

  assign commit = pending_o & tx_idle_i;

  cfg_shadow #(
    .DATA_W(REG_W), .DIV_W(DIV_W), .BRK_POS(BRK_BIT),
    .MODE_RST(MODE_RST), .PORT_RST(PORT_RST), .FMT_RST(FMT_RST), .DIV_RST(DIV_RST)
  ) i_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .port_we_i(port_we_i), .port_wdata_i(port_wdata_i),
    .fmt_we_i(fmt_we_i),   .fmt_wdata_i(fmt_wdata_i),
    .brk_we_i(brk_we_i),   .brk_val_i(brk_val_i),
    .div_we_i(div_we_i),   .div_wdata_i(div_wdata_i),
    .commit_i(commit),
    .sh_mode_o(sh_mode), .sh_port_o(sh_port), .sh_fmt_o(sh_fmt), .sh_div_o(sh_div),
    .pending_o(pending_o)
  );

  cfg_live #(
    .DATA_W(REG_W), .DIV_W(DIV_W),
    .MODE_RST(MODE_RST), .PORT_RST(PORT_RST), .FMT_RST(FMT_RST),
    .DIV_RST(DIV_RST), .AUX_RST(AUX_RST)
  ) i_live (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit),
    .sh_mode_i(sh_mode), .sh_port_i(sh_port), .sh_fmt_i(sh_fmt), .sh_div_i(sh_div),
    .aux_we_i(aux_we_i), .aux_wdata_i(aux_wdata_i),
    .mode_o(mode_o), .port_o(port_o), .fmt_o(fmt_o), .div_lo_o(div_lo_o), .aux_o(aux_o)
  );
endmodule

// File: rtl/uart_cfg_defer_chk.sv
module uart_cfg_defer_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              any_we,
  input logic              aux_we_i,
  input logic [DATA_W-1:0] aux_wdata_i,
  input logic              tx_idle_i,
  input logic              pending_o,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] port_o,
  input logic [DATA_W-1:0] fmt_o,
  input logic [DATA_W-1:0] div_lo_o,
  input logic [DATA_W-1:0] aux_o,
  input logic [DATA_W-1:0] sh_mode,
  input logic [DATA_W-1:0] sh_port,
  input logic [DATA_W-1:0] sh_fmt,
  input logic [DIV_W-1:0]  sh_div
);
  localparam int HI_W = DIV_W - DATA_W;
  localparam int LO_W = DATA_W - HI_W;

  p_we_sets_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_we |=> pending_o);

  p_live_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_o && tx_idle_i) |=> $stable(mode_o) && $stable(port_o) && $stable(fmt_o)
      && $stable(div_lo_o) && $stable(aux_o[DATA_W-1:LO_W]));

  p_commit_copies_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && tx_idle_i) |=> mode_o == $past(sh_mode) && port_o == $past(sh_port)
      && fmt_o == $past(sh_fmt) && div_lo_o == $past(sh_div[DATA_W-1:0]));

  p_div_split_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && tx_idle_i) |=> aux_o[DATA_W-1:LO_W] == $past(sh_div[DIV_W-1:DATA_W]));

  p_commit_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && tx_idle_i && !any_we) |=> !pending_o);

  p_busy_holds_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !tx_idle_i) |=> pending_o);

  p_aux_direct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_we_i |=> aux_o[LO_W-1:0] == $past(aux_wdata_i[LO_W-1:0]));

  p_aux_low_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_we_i |=> $stable(aux_o[LO_W-1:0]));
endmodule

bind uart_cfg_defer uart_cfg_defer_chk #(.DATA_W(uart_cfg_pkg::REG_W), .DIV_W(DIV_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .any_we(mode_we_i | port_we_i | fmt_we_i | brk_we_i | div_we_i),
  .aux_we_i(aux_we_i), .aux_wdata_i(aux_wdata_i), .tx_idle_i(tx_idle_i),
  .pending_o(pending_o), .mode_o(mode_o), .port_o(port_o), .fmt_o(fmt_o),
  .div_lo_o(div_lo_o), .aux_o(aux_o),
  .sh_mode(sh_mode), .sh_port(sh_port), .sh_fmt(sh_fmt), .sh_div(sh_div)
);

// File: tb/test_uart_cfg_defer.sv
module test_uart_cfg_defer;
  localparam logic [7:0] MODE_D = 8'h0C;
  localparam logic [7:0] PORT_D = 8'hFF;
  localparam logic [7:0] FMT_D  = 8'h03;
  localparam logic [9:0] DIV_D  = 10'h12F;
  localparam logic [7:0] AUX_D  = 8'h05;

  logic clk_i = 0, rst_ni = 0;
  logic mode_we_i = 0, port_we_i = 0, fmt_we_i = 0, brk_we_i = 0, div_we_i = 0, aux_we_i = 0;
  logic [7:0] mode_wdata_i = 0, port_wdata_i = 0, fmt_wdata_i = 0, aux_wdata_i = 0;
  logic [9:0] div_wdata_i = 0;
  logic brk_val_i = 0, tx_idle_i = 0;
  logic [7:0] mode_o, port_o, fmt_o, div_lo_o, aux_o;
  logic pending_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // expected live state
  logic [7:0] e_mode, e_port, e_fmt;
  logic [9:0] e_div;
  logic [5:0] e_auxlo;

  always #4 clk_i = ~clk_i;

  uart_cfg_defer #(.DIV_W(10), .MODE_RST(MODE_D), .PORT_RST(PORT_D), .FMT_RST(FMT_D),
                   .DIV_RST(DIV_D), .AUX_RST(AUX_D)) i_uart_cfg_defer (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    mode_we_i = 0; port_we_i = 0; fmt_we_i = 0; brk_we_i = 0; div_we_i = 0; aux_we_i = 0;
  endtask

  task automatic chk_live(input string tag);
    chk({tag, " mode"}, mode_o, e_mode);
    chk({tag, " port"}, port_o, e_port);
    chk({tag, " fmt"}, fmt_o, e_fmt);
    chk({tag, " divlo"}, div_lo_o, e_div[7:0]);
    chk({tag, " aux"}, aux_o, {e_div[9:8], e_auxlo});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    e_mode = MODE_D; e_port = PORT_D; e_fmt = FMT_D; e_div = DIV_D; e_auxlo = AUX_D[5:0];
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk_live("R1");
    chk("R1 pending", pending_o, 0);

    // R2 / R10: write while busy, hold
    tx_idle_i = 0; mode_we_i = 1; mode_wdata_i = 8'hA5;
    cyc();
    chk("R2 pending", pending_o, 1);
    chk_live("R2");
    repeat (6) cyc();
    chk("R10 pending held", pending_o, 1);
    chk_live("R10");
    tx_idle_i = 1;
    cyc();
    e_mode = 8'hA5;
    chk_live("R3 single");
    chk("R3 pending clr", pending_o, 0);

    // R3 several shadows committed together
    tx_idle_i = 0;
    mode_we_i = 1; mode_wdata_i = 8'h5A; cyc();
    port_we_i = 1; port_wdata_i = 8'h81; cyc();
    fmt_we_i = 1; fmt_wdata_i = 8'h1E; cyc();
    div_we_i = 1; div_wdata_i = 10'h2C3; cyc();
    chk_live("R3 busy");
    tx_idle_i = 1; cyc();
    e_mode = 8'h5A; e_port = 8'h81; e_fmt = 8'h1E; e_div = 10'h2C3;
    chk_live("R3 atomic");
    chk("R3 pending", pending_o, 0);

    // R4 write while already idle
    port_we_i = 1; port_wdata_i = 8'h3C; cyc();
    chk("R4 pending", pending_o, 1);
    chk("R4 not yet", port_o, e_port);
    cyc();
    e_port = 8'h3C;
    chk("R4 port", port_o, e_port);
    chk("R4 pending clr", pending_o, 0);

    // R9 write on commit edge
    mode_we_i = 1; mode_wdata_i = 8'h11; cyc();
    mode_we_i = 1; mode_wdata_i = 8'h22; cyc();
    e_mode = 8'h11;
    chk("R9 older value", mode_o, e_mode);
    chk("R9 still pending", pending_o, 1);
    cyc();
    e_mode = 8'h22;
    chk("R9 newer value", mode_o, e_mode);
    chk("R9 pending clr", pending_o, 0);

    // R6 aux low bits direct, R5 kept across commit
    tx_idle_i = 0;
    div_we_i = 1; div_wdata_i = 10'h1F0; cyc();
    aux_we_i = 1; aux_wdata_i = 8'hFF; cyc();
    e_auxlo = 6'h3F;
    chk("R6 aux direct", aux_o, {e_div[9:8], e_auxlo});
    chk("R6 pending", pending_o, 1);
    tx_idle_i = 1; cyc();
    e_div = 10'h1F0;
    chk("R5 aux low kept", aux_o, {e_div[9:8], e_auxlo});
    aux_we_i = 1; aux_wdata_i = 8'h12; cyc();
    e_auxlo = 6'h12;
    chk("R6 aux no pending", pending_o, 0);
    chk("R6 aux value", aux_o, {e_div[9:8], e_auxlo});

    // R7 break bit
    tx_idle_i = 0;
    brk_we_i = 1; brk_val_i = 1; cyc();
    chk("R7 deferred", fmt_o, e_fmt);
    tx_idle_i = 1; cyc();
    e_fmt = e_fmt | 8'h40;
    chk("R7 break set", fmt_o, e_fmt);
    tx_idle_i = 0;
    fmt_we_i = 1; fmt_wdata_i = 8'h00; brk_we_i = 1; brk_val_i = 1; cyc();
    tx_idle_i = 1; cyc();
    e_fmt = 8'h40;
    chk("R7 merge", fmt_o, e_fmt);
    tx_idle_i = 0;
    fmt_we_i = 1; fmt_wdata_i = 8'hFF; brk_we_i = 1; brk_val_i = 0; cyc();
    tx_idle_i = 1; cyc();
    e_fmt = 8'hBF;
    chk("R7 break clr", fmt_o, e_fmt);

    // R8 format sweep
    for (int v = 0; v < 256; v++) begin
      tx_idle_i = 0; fmt_we_i = 1; fmt_wdata_i = v[7:0]; cyc();
      chk("R8 held", fmt_o, e_fmt);
      tx_idle_i = 1; cyc();
      e_fmt = v[7:0];
      chk("R8 fmt", fmt_o, e_fmt);
    end

    // R5 divider sweep
    for (int v = 0; v < 1024; v++) begin
      tx_idle_i = 0; div_we_i = 1; div_wdata_i = v[9:0]; cyc();
      chk("R5 held", aux_o, {e_div[9:8], e_auxlo});
      tx_idle_i = 1; cyc();
      e_div = v[9:0];
      chk("R5 lo", div_lo_o, e_div[7:0]);
      chk("R5 hi", aux_o, {e_div[9:8], e_auxlo});
    end
    chk_live("R3 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule